// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Interrupt Controller

This block gathers the pending flags of a large bank of GPIO pins into a compact summary vector and drives one shared interrupt line to the processor. Pins are grouped in fours. Each group contributes one summary bit, so the default 184 pins give 46 summary bits. Software reads these bits as two 32-bit status words. An interrupt handler reads the status words to find the active groups, services the pins, and then writes an end-of-interrupt command. The line stays quiet from the read until that command arrives.

A control register holds two things: the length of a status-blocking window, and an enable for that window. When the enable is set, any software write to a pin's debounce setup, signalled by a strobe, starts the window. While the window is open, summary generation is suppressed for every pin, and the per-pin interrupt-enable bits presented back to software read as 0. The window length counts reference-clock ticks. Per-pin edge and level detection sits outside this block.

Top module: `pin_irq_summary`

## Requirements
- R1: Summary bit n is the OR of pending inputs 4n, 4n+1, 4n+2 and 4n+3. It is registered and reflects the inputs one clock after they change.
- R2: Reading address 0 returns summary bits 31..0. Reading address 1 returns summary bits 45..32 in data bits 13..0, and data bits 31..14 read as 0.
- R3: `irq_o` is high when the unit is armed and at least one summary bit is set. With no summary bit set, `irq_o` is low.
- R4: A read strobe to address 0 or 1 while `irq_o` is high disarms the unit. `irq_o` is then low from the next cycle and stays low until an end-of-interrupt command.
- R5: Writing address 2 with data bit 13 set is the end-of-interrupt command. It re-arms the unit from the next cycle, and `irq_o` reasserts if any summary bit is set. Bit 13 always reads back as 0.
- R6: Address 2 holds the window length in bits 11..0 and the blocking enable in bit 12. Both read back as written, and both are 0 after reset.
- R7: With blocking enabled, a `dbg_wr_i` pulse makes `irq_en_o` read all zeros for exactly "length" cycles when `ref_tick_i` is high every cycle. The summary reads 0 from the second blocked cycle until one cycle after the window closes. A length of 0 opens no window.
- R8: A `dbg_wr_i` pulse during an open window restarts the window at the full length.
- R9: With blocking disabled, `dbg_wr_i` has no effect: `irq_en_o` follows `irq_en_i`, and the summary is unchanged.
- R10: After reset, the unit is armed, the summary is 0, the control register is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle tick of the reference clock that times the blocking window |
| pend_i | input | 184 | Per-pin pending flags |
| irq_en_i | input | 184 | Per-pin interrupt-enable bits from pin configuration |
| dbg_wr_i | input | 1 | Strobe: software wrote some pin's debounce setup |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| irq_en_o | output | 184 | Interrupt-enable bits as seen by software (0 while blocking) |
| irq_o | output | 1 | Shared interrupt line |

## Verification
A wrong group mapping shows up on the status words one cycle after a single pin is raised. The bench therefore raises each pin alone and checks the whole 64-bit view. A stuck arm flag appears in one of two ways: the line rises again right after a status read, or the line stays low after an end-of-interrupt command while a bit is pending. Both are visible on the next cycle. A window counter that is off by one, fails to reload, or ignores the enable changes the number of cycles during which `irq_en_o` reads zero. The bench measures that count for a sweep of lengths, for a restart, and for the disabled case.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam logic [1:0] ADDR_SUM_LO = 2'd0;
  localparam logic [1:0] ADDR_SUM_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam int CTRL_EN_BIT  = 12;
  localparam int CTRL_EOI_BIT = 13;
  localparam int LEN_W        = 12;

  typedef struct packed {
    logic             blk_en;
    logic [LEN_W-1:0] blk_len;
  } ctrl_t;
endpackage

// File: rtl/pin_group_or.sv
module pin_group_or #(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4,
  localparam int NSUM    = NUM_PINS / GRP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic                block_i,
  output logic [NSUM-1:0]     sum_o
);
  logic [NSUM-1:0] grp_or;

  for (genvar g = 0; g < NSUM; g++) begin : g_grp
    assign grp_or[g] = |pend_i[g*GRP +: GRP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_o <= '0;
    else if (block_i) sum_o <= '0;
    else              sum_o <= grp_or;
  end

  // R1: unblocked pins with no pending flag leave the summary empty
  p_idle_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (sum_o == '0));
endmodule

// File: rtl/block_window.sv
module block_window #(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             active_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i && en_i)         cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && en_i && len_i != '0) |=> active_o);
  p_no_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !(start_i && en_i)) |=> !active_o);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && en_i) |=> (cnt_q == $past(len_i)));
endmodule

// File: rtl/irq_arm.sv
module irq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic take_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b1;
    else if (eoi_i)  armed_q <= 1'b1;
    else if (take_i) armed_q <= 1'b0;
  end

  assign irq_o = armed_q & any_i;

  p_take_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !eoi_i) |=> !irq_o);
  p_stay_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !eoi_i) |=> !irq_o);
  p_eoi_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i |=> armed_q);
endmodule

// File: rtl/pin_irq_summary.sv
module pin_irq_summary
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4,
  parameter int DATA_W   = 32,
  localparam int NSUM    = NUM_PINS / GRP,
  localparam int EXT_W   = 2 * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_tick_i,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] irq_en_i,
  input  logic                dbg_wr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] irq_en_o,
  output logic                irq_o
);
  ctrl_t           ctrl_q;
  logic            blocking;
  logic [NSUM-1:0] sum;
  logic [EXT_W-1:0] sum_ext;
  logic            ctrl_wr, eoi, take;
  logic            unused_w;

  assign ctrl_wr  = wr_i && (addr_i == ADDR_CTRL);
  assign eoi      = ctrl_wr && wdata_i[CTRL_EOI_BIT];
  assign take     = rd_i && irq_o &&
                    (addr_i == ADDR_SUM_LO || addr_i == ADDR_SUM_HI);
  assign unused_w = ^wdata_i[DATA_W-1:CTRL_EOI_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_EN_BIT:0]);
  end

  pin_group_or #(.NUM_PINS(NUM_PINS), .GRP(GRP)) u_grp (
    .clk_i, .rst_ni, .pend_i, .block_i(blocking), .sum_o(sum)
  );

  block_window #(.LEN_W(LEN_W)) u_win (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.blk_en), .len_i(ctrl_q.blk_len),
    .start_i(dbg_wr_i), .tick_i(ref_tick_i), .active_o(blocking)
  );

  irq_arm u_arm (
    .clk_i, .rst_ni, .any_i(|sum), .take_i(take), .eoi_i(eoi), .irq_o
  );

  assign sum_ext  = EXT_W'(sum);
  assign irq_en_o = irq_en_i & ~{NUM_PINS{blocking}};

  always_comb begin
    unique case (addr_i)
      ADDR_SUM_LO: rdata_o = sum_ext[DATA_W-1:0];
      ADDR_SUM_HI: rdata_o = sum_ext[EXT_W-1:DATA_W];
      ADDR_CTRL:   rdata_o = DATA_W'(ctrl_q);
      default:     rdata_o = '0;
    endcase
  end

  p_blocked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocking |=> (sum == '0 && !irq_o));
  p_irq_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sum != '0));
endmodule

// File: tb/pin_irq_summary_bench.sv
`timescale 1ns/1ps
module pin_irq_summary_bench;
  localparam int NP = 184;
  logic clk = 0, rst_n = 0;
  logic ref_tick = 1;
  logic [NP-1:0] pend = '0, en_in = '1, en_out;
  logic dbw = 0, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_irq_summary u_pin_irq_summary (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pend_i(pend),
    .irq_en_i(en_in), .dbg_wr_i(dbw), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_en_o(en_out), .irq_o(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] summ(logic [NP-1:0] p);
    logic [63:0] s = '0;
    for (int g = 0; g < NP / 4; g++) s[g] = |p[g*4 +: 4];
    return s;
  endfunction

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic read_sum(output logic [63:0] s);
    logic [31:0] lo, hi;
    peek(2'd0, lo); peek(2'd1, hi);
    s = {hi, lo};
  endtask

  task automatic wr_ctrl(logic [31:0] d);
    addr = 2'd2; wdata = d; wr = 1; step(); wr = 0;
  endtask

  task automatic take_irq();
    addr = 2'd0; rd = 1; step(); rd = 0;
  endtask

  // pulse dbg write, then count cycles with irq_en_o all zero
  task automatic pulse_count(output int n, output logic [63:0] s2);
    dbw = 1; step(); dbw = 0;
    n = 0; s2 = '1;
    while (en_out == '0 && n < 100) begin
      n++;
      if (n == 2) read_sum(s2);
      step();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] s, s2;
    logic [31:0] d;
    int n;
    step(2); rst_n = 1; step();
    // R10 reset state
    chk("R10 irq", 64'(irq), 0);
    read_sum(s); chk("R10 sum", s, 0);
    peek(2'd2, d); chk("R10 ctrl", 64'(d), 0);

    // R1 R2 R3: each pin alone
    for (int p = 0; p < NP; p++) begin
      pend = '0; pend[p] = 1'b1; step();
      read_sum(s);
      chk("R1 R2 single pin", s, 64'd1 << (p / 4));
      chk("R3 irq on pending", 64'(irq), 1);
    end
    // R1: all patterns inside one group and a neighbour
    for (int v = 0; v < 256; v++) begin
      pend = '0; pend[11:4] = 8'(v); step();
      read_sum(s);
      chk("R1 group pattern", s, summ(pend));
    end
    pend = '0; pend[NP-1] = 1'b1; pend[0] = 1'b1; step();
    read_sum(s); chk("R2 ends", s, summ(pend));
    pend = '0; step();
    chk("R3 no pending", 64'(irq), 0);

    // R4 R5
    pend[10] = 1'b1; step();
    chk("R3 set", 64'(irq), 1);
    take_irq();
    chk("R4 drop after read", 64'(irq), 0);
    step(5);
    chk("R4 stays low", 64'(irq), 0);
    wr_ctrl(32'h2000);
    chk("R5 reassert", 64'(irq), 1);
    peek(2'd2, d); chk("R5 eoi reads 0", 64'(d[13]), 0);
    take_irq(); pend = '0; step();
    wr_ctrl(32'h2000);
    chk("R5 armed idle", 64'(irq), 0);
    pend[100] = 1'b1; step();
    chk("R5 armed new", 64'(irq), 1);

    // R6
    wr_ctrl(32'h0000_1005);
    peek(2'd2, d); chk("R6 readback", 64'(d), 64'h1005);
    wr_ctrl(32'h0000_0ABC);
    peek(2'd2, d); chk("R6 readback2", 64'(d), 64'h0ABC);

    // R7 length sweep
    for (int l = 0; l <= 9; l++) begin
      wr_ctrl(32'h1000 | 32'(l));
      pulse_count(n, s2);
      chk("R7 window length", 64'(n), 64'(l));
      if (l >= 2) chk("R7 sum blocked", s2, 0);
      step();
      read_sum(s); chk("R7 sum restored", s, summ(pend));
    end

    // R8 restart
    wr_ctrl(32'h1006);
    dbw = 1; step(); dbw = 0; step(2);
    pulse_count(n, s2);
    chk("R8 restart length", 64'(n), 6);
    step();

    // R9 disabled
    wr_ctrl(32'h0005);
    dbw = 1; step(); dbw = 0;
    for (int i = 0; i < 6; i++) begin
      chk("R9 en passes", 64'(en_out == en_in), 1);
      read_sum(s); chk("R9 sum kept", s, summ(pend));
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule